// File: doc/BRIEF.md
# Dual-Port Hardware Lock Bank

This block holds a parameterised set of one-bit hardware locks that two processor ports share. A processor takes a lock by reading its entry. If the entry was free, the read returns 0 and the entry becomes held in that same access. If the entry was already held, the read returns 1 and the entry stays as it was. Software therefore spins on a read until it sees 0, works on the shared resource, and then frees the entry by writing 0 to it.

Each port has a plain synchronous register interface: valid, write, byte address, write data, read data and ready. Every access finishes in the cycle it is presented. When both ports touch the same entry in one cycle, fixed rules make the result deterministic. A release is applied before any lock-read. Between two lock-reads, port 0 wins. The block does not record which port holds a lock, so either port may free any entry.

Top module: `mtx_bank`

## Requirements
- R1: After reset every entry is free, so the first read of any entry returns 0.
- R2: A read of a free entry returns 0 in bit 0 and leaves the entry held from the next cycle on.
- R3: A read of a held entry returns 1 in bit 0 and leaves the entry held.
- R4: A write whose data bit 0 is 0 frees the addressed entry. A write whose data bit 0 is 1 changes nothing.
- R5: Entry n sits at byte address 0x400 + 4·n for n below the entry count. Any other address, including a misaligned one (address bits 1:0 not 00), reads as 0 and has no effect on any entry.
- R6: When both ports read the same free entry in one cycle, port 0 reads 0 and port 1 reads 1, and the entry ends up held.
- R7: When one port frees an entry and the other reads it in the same cycle, the free is applied first: the reader gets 0 and the entry ends up held.
- R8: Read data bits 31:1 are always 0, and ready equals valid in the same cycle.
- R9: Either port may free an entry, whichever port took it.
- R10: Accesses by the two ports to different entries in one cycle act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| p0_valid | input | 1 | Port 0 access request |
| p0_write | input | 1 | Port 0: 1 = write, 0 = read |
| p0_addr | input | ADDR_W | Port 0 byte address |
| p0_wdata | input | 32 | Port 0 write data; bit 0 is used |
| p0_rdata | output | 32 | Port 0 read data; bit 0 is the lock result |
| p0_ready | output | 1 | Port 0 access complete |
| p1_valid | input | 1 | Port 1 access request |
| p1_write | input | 1 | Port 1: 1 = write, 0 = read |
| p1_addr | input | ADDR_W | Port 1 byte address |
| p1_wdata | input | 32 | Port 1 write data; bit 0 is used |
| p1_rdata | output | 32 | Port 1 read data; bit 0 is the lock result |
| p1_ready | output | 1 | Port 1 access complete |

## Verification
The bench builds the block with four entries and a 12-bit address. With only four entries, random traffic from the two ports lands on the same entry often, so collisions of read with read and of release with read occur many times per run. The small count also puts the first out-of-range address (0x410) right next to the last entry, so the upper edge of the decode is exercised together with addresses below the base and misaligned addresses.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int unsigned MTX_DATA_W = 32;

  typedef struct packed {
    logic rd;   // lock-read hit on this entry
    logic rel;  // release (write of 0) hit on this entry
  } mtx_cmd_t;
endpackage

// File: rtl/mtx_rst_sync.sv
module mtx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/mtx_decode.sv
module mtx_decode
  import mtx_pkg::*;
#(
  parameter int unsigned N_ENT    = 16,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BASE_OFF = 32'h400
) (
  input  logic                 valid,
  input  logic                 write,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wbit,
  output mtx_cmd_t [N_ENT-1:0] cmd
);
  localparam int unsigned SPAN = 4 * N_ENT;

  logic [ADDR_W-1:0] off;
  logic              in_rng;

  always_comb begin
    off    = addr - ADDR_W'(BASE_OFF);
    in_rng = valid
          && (addr >= ADDR_W'(BASE_OFF))
          && (off < ADDR_W'(SPAN))
          && (addr[1:0] == 2'b00);
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic sel;
    assign sel        = in_rng && (off[ADDR_W-1:2] == (ADDR_W-2)'(e));
    assign cmd[e].rd  = sel && !write;
    assign cmd[e].rel = sel && write && !wbit;
  end
endmodule

// File: rtl/mtx_cell.sv
module mtx_cell
  import mtx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  mtx_cmd_t cmd0,
  input  mtx_cmd_t cmd1,
  output logic     rbit0,
  output logic     rbit1,
  output logic     lk_q
);
  logic eff;
  logic lk_d;
  logic lk_en;

  always_comb begin
    // release is applied ahead of any lock-read in the same cycle
    eff   = lk_q && !(cmd0.rel || cmd1.rel);
    rbit0 = cmd0.rd && eff;
    // port 0 has priority: its read takes the lock before port 1 sees it
    rbit1 = cmd1.rd && (eff || cmd0.rd);
    lk_d  = eff || cmd0.rd || cmd1.rd;
    lk_en = cmd0.rd || cmd0.rel || cmd1.rd || cmd1.rel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lk_q <= 1'b0;
    else if (lk_en) lk_q <= lk_d;
  end
endmodule

// File: rtl/mtx_bank.sv
module mtx_bank
  import mtx_pkg::*;
#(
  parameter int unsigned N_ENT    = 16,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BASE_OFF = 32'h400
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  p0_valid,
  input  logic                  p0_write,
  input  logic [ADDR_W-1:0]     p0_addr,
  input  logic [MTX_DATA_W-1:0] p0_wdata,
  output logic [MTX_DATA_W-1:0] p0_rdata,
  output logic                  p0_ready,
  input  logic                  p1_valid,
  input  logic                  p1_write,
  input  logic [ADDR_W-1:0]     p1_addr,
  input  logic [MTX_DATA_W-1:0] p1_wdata,
  output logic [MTX_DATA_W-1:0] p1_rdata,
  output logic                  p1_ready
);
  logic                 rst_n_s;
  mtx_cmd_t [N_ENT-1:0] cmd0;
  mtx_cmd_t [N_ENT-1:0] cmd1;
  logic [N_ENT-1:0]     rb0;
  logic [N_ENT-1:0]     rb1;
  logic [N_ENT-1:0]     lk_state;
  logic                 unused_wdata;

  assign unused_wdata = ^{p0_wdata[MTX_DATA_W-1:1], p1_wdata[MTX_DATA_W-1:1]};

  mtx_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  mtx_decode #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)) i_dec0 (
    .valid (p0_valid),
    .write (p0_write),
    .addr  (p0_addr),
    .wbit  (p0_wdata[0]),
    .cmd   (cmd0)
  );

  mtx_decode #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)) i_dec1 (
    .valid (p1_valid),
    .write (p1_write),
    .addr  (p1_addr),
    .wbit  (p1_wdata[0]),
    .cmd   (cmd1)
  );

  for (genvar e = 0; e < N_ENT; e++) begin : g_cell
    mtx_cell i_cell (
      .clk   (clk),
      .rst_n (rst_n_s),
      .cmd0  (cmd0[e]),
      .cmd1  (cmd1[e]),
      .rbit0 (rb0[e]),
      .rbit1 (rb1[e]),
      .lk_q  (lk_state[e])
    );
  end

  assign p0_rdata = {{(MTX_DATA_W-1){1'b0}}, |rb0};
  assign p1_rdata = {{(MTX_DATA_W-1){1'b0}}, |rb1};
  assign p0_ready = p0_valid;
  assign p1_ready = p1_valid;
endmodule

// File: rtl/mtx_bank_chk.sv
module mtx_bank_chk #(
  parameter int unsigned N_ENT    = 16,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BASE_OFF = 32'h400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              p0_valid,
  input logic              p0_write,
  input logic [ADDR_W-1:0] p0_addr,
  input logic              p0_wbit,
  input logic [31:0]       p0_rdata,
  input logic              p0_ready,
  input logic              p1_valid,
  input logic              p1_write,
  input logic [ADDR_W-1:0] p1_addr,
  input logic [31:0]       p1_rdata,
  input logic              p1_ready,
  input logic [N_ENT-1:0]  lk_state
);
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic             in0;
  logic             in1;
  logic [IDX_W-1:0] idx0;
  logic             rd0;
  logic             rd1;

  always_comb begin
    logic [ADDR_W-1:0] o0;
    logic [ADDR_W-1:0] o1;
    o0   = p0_addr - ADDR_W'(BASE_OFF);
    o1   = p1_addr - ADDR_W'(BASE_OFF);
    in0  = (p0_addr >= ADDR_W'(BASE_OFF)) && (o0 < ADDR_W'(4 * N_ENT)) && (p0_addr[1:0] == 2'b00);
    in1  = (p1_addr >= ADDR_W'(BASE_OFF)) && (o1 < ADDR_W'(4 * N_ENT)) && (p1_addr[1:0] == 2'b00);
    idx0 = o0[IDX_W+1:2];
    rd0  = p0_valid && !p0_write;
    rd1  = p1_valid && !p1_write;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> lk_state == '0);

  assert_lock_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 && in0 && !p0_rdata[0] |=> lk_state[$past(idx0)]);

  assert_locked_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 && in0 && lk_state[idx0] && !(p1_valid && p1_write) |-> p0_rdata[0]);

  assert_wr1_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    p0_valid && p0_write && p0_wbit && !p1_valid |=> $stable(lk_state));

  assert_outside_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 && !in0 |-> p0_rdata == 32'd0);

  assert_one_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 && rd1 && in0 && in1 && (p0_addr == p1_addr) |-> p1_rdata[0]);

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_rdata[31:1] == '0) && (p1_rdata[31:1] == '0));

  assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_ready == p0_valid) && (p1_ready == p1_valid));
endmodule

bind mtx_bank mtx_bank_chk #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .p0_valid (p0_valid),
  .p0_write (p0_write),
  .p0_addr  (p0_addr),
  .p0_wbit  (p0_wdata[0]),
  .p0_rdata (p0_rdata),
  .p0_ready (p0_ready),
  .p1_valid (p1_valid),
  .p1_write (p1_write),
  .p1_addr  (p1_addr),
  .p1_rdata (p1_rdata),
  .p1_ready (p1_ready),
  .lk_state (lk_state)
);

// File: tb/test_mtx_bank.sv
module test_mtx_bank;
  localparam int PERIOD = 10;
  localparam int NE     = 4;
  localparam int AW     = 12;
  localparam int BASE   = 'h400;

  logic          clk;
  logic          rst_n;
  logic          p0_valid, p0_write, p0_ready;
  logic          p1_valid, p1_write, p1_ready;
  logic [AW-1:0] p0_addr, p1_addr;
  logic [31:0]   p0_wdata, p1_wdata, p0_rdata, p1_rdata;

  int  n_chk;
  int  n_fail;
  bit  done;
  bit  model_lk [NE];

  mtx_bank #(.N_ENT(NE), .ADDR_W(AW), .BASE_OFF(BASE)) i_mtx_bank (
    .clk(clk), .rst_n(rst_n),
    .p0_valid(p0_valid), .p0_write(p0_write), .p0_addr(p0_addr),
    .p0_wdata(p0_wdata), .p0_rdata(p0_rdata), .p0_ready(p0_ready),
    .p1_valid(p1_valid), .p1_write(p1_write), .p1_addr(p1_addr),
    .p1_wdata(p1_wdata), .p1_rdata(p1_rdata), .p1_ready(p1_ready)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  function automatic bit hits(input int a);
    return (a >= BASE) && (a < BASE + 4*NE) && (a % 4 == 0);
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one bus cycle on both ports, compared against the behavioural model
  task automatic step(input string tag,
                      input bit v0, input bit w0, input int a0, input int d0,
                      input bit v1, input bit w1, input int a1, input int d1);
    bit    nxt [NE];
    int    e0, e1;
    @(negedge clk);
    p0_valid = v0; p0_write = w0; p0_addr = AW'(a0); p0_wdata = 32'(d0);
    p1_valid = v1; p1_write = w1; p1_addr = AW'(a1); p1_wdata = 32'(d1);
    nxt = model_lk;
    if (v0 && w0 && hits(a0) && d0[0] == 1'b0) nxt[(a0-BASE)/4] = 1'b0;
    if (v1 && w1 && hits(a1) && d1[0] == 1'b0) nxt[(a1-BASE)/4] = 1'b0;
    e0 = 0;
    if (v0 && !w0 && hits(a0)) begin
      e0 = nxt[(a0-BASE)/4];
      nxt[(a0-BASE)/4] = 1'b1;
    end
    e1 = 0;
    if (v1 && !w1 && hits(a1)) begin
      e1 = nxt[(a1-BASE)/4];
      nxt[(a1-BASE)/4] = 1'b1;
    end
    #1;
    check(tag, "p0_rdata", p0_rdata, 32'(e0));
    check(tag, "p1_rdata", p1_rdata, 32'(e1));
    check(tag, "ready", {30'd0, p1_ready, p0_ready}, {30'd0, v1, v0});
    model_lk = nxt;
  endtask

  task automatic rd0(input string t, input int a); step(t, 1, 0, a, 0, 0, 0, 0, 0); endtask
  task automatic rd1(input string t, input int a); step(t, 0, 0, 0, 0, 1, 0, a, 0); endtask
  task automatic wr0(input string t, input int a, input int d); step(t, 1, 1, a, d, 0, 0, 0, 0); endtask
  task automatic wr1(input string t, input int a, input int d); step(t, 0, 0, 0, 0, 1, 1, a, d); endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    foreach (model_lk[i]) model_lk[i] = 1'b0;
    rst_n = 1'b0;
    p0_valid = 0; p0_write = 0; p0_addr = '0; p0_wdata = '0;
    p1_valid = 0; p1_write = 0; p1_addr = '0; p1_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: idle after reset, then every entry is free on first read (R2 locks it)
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < NE; i++) rd0("R1", BASE + 4*i);
    // R3: held entry reads 1 from both ports
    rd0("R3", BASE);
    rd1("R3", BASE);
    // R9: port 1 frees a lock port 0 took; R2 re-lock
    wr1("R9", BASE, 0);
    rd0("R2", BASE);
    // R4: free, write 1 is ignored, next read takes it
    wr0("R4", BASE + 4, 0);
    wr0("R4", BASE + 4, 1);
    rd1("R4", BASE + 4);
    rd0("R4", BASE + 4);
    // R5: out of range, misaligned, below base; no effect on entries
    wr0("R5", BASE + 4*NE, 0);
    rd0("R5", BASE + 4*NE);
    rd0("R5", BASE + 4*NE);
    rd1("R5", BASE + 2);
    rd0("R5", BASE - 4);
    wr1("R5", BASE + 6, 0);
    rd0("R5", BASE + 4);
    // R6: both read the same free entry
    wr0("R6", BASE + 8, 0);
    step("R6", 1, 0, BASE + 8, 0, 1, 0, BASE + 8, 0);
    rd1("R6", BASE + 8);
    // R7: release and read in one cycle, both directions
    step("R7", 1, 0, BASE + 8, 0, 1, 1, BASE + 8, 0);
    step("R7", 1, 1, BASE + 8, 0, 1, 0, BASE + 8, 0);
    rd0("R7", BASE + 8);
    // R10: different entries at once
    wr0("R10", BASE + 12, 0);
    step("R10", 1, 0, BASE + 12, 0, 1, 0, BASE + 8, 0);
    step("R10", 1, 1, BASE + 12, 0, 1, 0, BASE, 0);

    // R8 / R10: random two-port traffic compared every cycle
    for (int n = 0; n < 600; n++) begin
      int a0, a1;
      bit v0, v1, w0, w1;
      a0 = BASE - 4 + 2 * int'($urandom_range(0, 2*NE + 3));
      a1 = BASE - 4 + 2 * int'($urandom_range(0, 2*NE + 3));
      if ($urandom_range(0, 3) != 0) a0 = a0 & ~3;
      if ($urandom_range(0, 3) != 0) a1 = a1 & ~3;
      v0 = ($urandom_range(0, 4) != 0);
      v1 = ($urandom_range(0, 4) != 0);
      w0 = ($urandom_range(0, 2) == 0);
      w1 = ($urandom_range(0, 2) == 0);
      step("R8", v0, w0, a0, int'($urandom), v1, w1, a1, int'($urandom));
    end

    report();
  end
endmodule